// File: doc/BRIEF.md
# Spread Spectrum Modulation Controller

This block produces the triangular frequency-modulation profile for a spread-spectrum clock synthesizer. It runs on the reference clock. Each cycle it outputs a signed frequency-offset word that the synthesizer's loop adds to its nominal setting. The offset ramps linearly up and down between a negative and a positive peak of equal size. The spread is therefore centred on the nominal frequency, and the average output frequency equals the nominal one.

A two-bit range code selects the length of the modulation period and whether the output multiplier is 1X or 2X. An unsigned peak-deviation code sets the size of the swing. The modulation-enable input turns the modulation off, which turns the synthesizer into a plain clock source. After any change of range or enable, the ramp restarts from its midpoint, where the offset is zero, so the output frequency never jumps.

Top module: `ssm_ctrl`

## Requirements
- R1: While `rst_ni` is low, and before the first clock edge after it rises, `offset_o` is 0, `range_err_o` is 0 and `mult2_o` is 0. The captured enable resets to on and the captured range code resets to 00. The ramp position resets to floor(HALF/2), rising.
- R2: Range codes 00 and 01 give a ramp limit L = HALF (583 by default). The ramp position p steps by exactly 1 every cycle. It rises to L and then falls to 0, so one modulation period is 2·L reference cycles (1166 by default).
- R3: Range code 10 gives L = 2·HALF, which makes a period of 4·HALF reference cycles (2332 by default).
- R4: Range code 11 is invalid. One cycle after the code is applied, `range_err_o` is 1 and `offset_o` is 0, and both stay so while the code is held.
- R5: `mult2_o` is 1 one cycle after range code 01 is applied. For every other code it is 0.
- R6: While modulation is active, `offset_o` = ((2·p − L)·dev_i) / L, truncated toward zero. The ends of the ramp give exactly +dev_i and −dev_i, dev_i = 0 gives 0, and |offset_o| never exceeds dev_i.
- R7: `mod_en_i` = 0 forces `offset_o` to 0 from the next cycle on. Changing `mod_en_i` restarts the ramp.
- R8: The inputs are captured at every clock edge. If the captured range code or enable differs from the value captured at the edge before, the position reloads to floor(L/2) of the new code and the ramp direction is set to rising. That point gives offset 0 when L is even, or when dev_i < L.
- R9: Centre spread: the sum of `offset_o` over any 2·L consecutive cycles of steady operation is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mod_en_i | input | 1 | 1 = modulation runs, 0 = offset held at zero |
| range_i | input | 2 | Range code: 00 short/1X, 01 short/2X, 10 long/1X, 11 invalid |
| dev_i | input | DEV_W (8) | Peak deviation, unsigned |
| offset_o | output | OFS_W (16) | Signed two's-complement frequency offset |
| range_err_o | output | 1 | Invalid range code captured |
| mult2_o | output | 1 | 2X output multiplication selected |

## Verification
The bench builds the block with HALF = 6. This gives ramp limits of 6 and 12, and short and long periods of 12 and 24 cycles. With these values every turnaround, several full periods of both ranges, and the exact zero-offset restart point can be reached within a few dozen cycles. Both limits are even, so the truncation rounding and the symmetric pairing of values around zero can be checked exactly. The default HALF = 583 uses the same logic and differs only in the constant divisors.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  typedef enum logic [1:0] {
    RNG_1X   = 2'b00,
    RNG_2X   = 2'b01,
    RNG_SLOW = 2'b10,
    RNG_BAD  = 2'b11
  } rng_e;

  function automatic int unsigned ramp_lim(input logic [1:0] r, input int unsigned half);
    return (r == RNG_SLOW) ? 2 * half : half;
  endfunction
endpackage

// File: rtl/ssm_range_dec.sv
module ssm_range_dec
  import ssm_pkg::*;
#(
  parameter int unsigned HALF = 583,
  parameter int unsigned PW   = 11
) (
  input  logic [1:0]    rng_i,
  output logic [PW-1:0] lim_o,
  output logic          valid_o,
  output logic          slow_o,
  output logic          mult2_o
);
  always_comb begin
    lim_o   = PW'(ramp_lim(rng_i, HALF));
    valid_o = (rng_i != RNG_BAD);
    slow_o  = (rng_i == RNG_SLOW);
    mult2_o = (rng_i == RNG_2X);
  end
endmodule

// File: rtl/ssm_ramp.sv
module ssm_ramp #(
  parameter int unsigned PW      = 11,
  parameter logic [PW-1:0] RST_MID = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic [PW-1:0] mid_i,
  input  logic [PW-1:0] lim_i,
  output logic [PW-1:0] pos_o
);
  logic [PW-1:0] pos_q;
  logic          up_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= RST_MID;
      up_q  <= 1'b1;
    end else if (restart_i) begin
      pos_q <= mid_i;
      up_q  <= 1'b1;
    end else if (up_q) begin
      pos_q <= pos_q + 1'b1;
      if (pos_q == lim_i - 1'b1) up_q <= 1'b0;
    end else begin
      pos_q <= pos_q - 1'b1;
      if (pos_q == {{(PW-1){1'b0}}, 1'b1}) up_q <= 1'b1;
    end
  end

  assign pos_o = pos_q;

  // R2: position moves by exactly one per cycle outside restarts
  a_r2_unit_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart_i |=> (pos_q == $past(pos_q) + 1'b1) || (pos_q == $past(pos_q) - 1'b1));

  // R8: restart lands on the midpoint
  a_r8_restart_mid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> pos_q == $past(mid_i));

  // R2: position stays within the ramp
  a_r2_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart_i |=> pos_q <= $past(lim_i));
endmodule

// File: rtl/ssm_scale.sv
module ssm_scale #(
  parameter int unsigned HALF  = 583,
  parameter int unsigned PW    = 11,
  parameter int unsigned DEV_W = 8,
  parameter int unsigned OFS_W = 16
) (
  input  logic [PW-1:0]           pos_i,
  input  logic                    slow_i,
  input  logic [DEV_W-1:0]        dev_i,
  input  logic                    active_i,
  output logic signed [OFS_W-1:0] offset_o
);
  localparam int LIM_S = int'(HALF);
  localparam int LIM_L = 2 * int'(HALF);

  int span, num, quo;

  always_comb begin
    span = 2 * int'(pos_i) - (slow_i ? LIM_L : LIM_S);
    num  = span * int'(dev_i);
    quo  = slow_i ? (num / LIM_L) : (num / LIM_S);
    offset_o = active_i ? OFS_W'(quo) : '0;
  end
endmodule

// File: rtl/ssm_ctrl.sv
module ssm_ctrl
  import ssm_pkg::*;
#(
  parameter int unsigned HALF  = 583,
  parameter int unsigned DEV_W = 8,
  parameter int unsigned OFS_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    mod_en_i,
  input  logic [1:0]              range_i,
  input  logic [DEV_W-1:0]        dev_i,
  output logic signed [OFS_W-1:0] offset_o,
  output logic                    range_err_o,
  output logic                    mult2_o
);
  localparam int unsigned PW = $clog2(2 * HALF + 1) + 1;
  localparam logic [PW-1:0] RST_MID = PW'(HALF / 2);

  logic          en_q;
  logic [1:0]    rng_q;
  logic [PW-1:0] lim_q, mid_n, pos;
  logic          valid_q, slow_q, mult2_q;
  logic          act_n, restart;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b1;
      rng_q <= RNG_1X;
    end else begin
      en_q  <= mod_en_i;
      rng_q <= range_i;
    end
  end

  ssm_range_dec #(.HALF(HALF), .PW(PW)) u_dec (
    .rng_i  (rng_q),
    .lim_o  (lim_q),
    .valid_o(valid_q),
    .slow_o (slow_q),
    .mult2_o(mult2_q)
  );

  always_comb begin
    mid_n   = PW'(ramp_lim(range_i, HALF) / 2);
    act_n   = mod_en_i && (range_i != RNG_BAD);
    restart = !act_n || (mod_en_i != en_q) || (range_i != rng_q);
  end

  ssm_ramp #(.PW(PW), .RST_MID(RST_MID)) u_ramp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart),
    .mid_i    (mid_n),
    .lim_i    (lim_q),
    .pos_o    (pos)
  );

  ssm_scale #(.HALF(HALF), .PW(PW), .DEV_W(DEV_W), .OFS_W(OFS_W)) u_scale (
    .pos_i   (pos),
    .slow_i  (slow_q),
    .dev_i   (dev_i),
    .active_i(en_q && valid_q),
    .offset_o(offset_o)
  );

  assign range_err_o = !valid_q;
  assign mult2_o     = mult2_q;

  // R7
  a_r7_disable_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mod_en_i |=> offset_o == '0);

  // R4
  a_r4_bad_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (range_i == RNG_BAD) |=> (range_err_o && offset_o == '0));

  // R5
  a_r5_mult2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (range_i == RNG_2X) |=> mult2_o);

  // R6
  a_r6_peak_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(offset_o) <= int'(dev_i)) && (int'(offset_o) >= -int'(dev_i)));
endmodule

// File: tb/tb_ssm_ctrl.sv
module tb_ssm_ctrl;
  localparam int H = 6;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              mod_en_i = 1'b1;
  logic [1:0]        range_i = 2'b00;
  logic [7:0]        dev_i = 8'd100;
  logic signed [15:0] offset_o;
  logic              range_err_o, mult2_o;

  int total = 0;
  int bad = 0;

  // bench-side model of the requirement state
  int mp, mdir, men, mrng;
  int acc, vmax, vmin;

  always #4 clk = ~clk;

  ssm_ctrl #(.HALF(H), .DEV_W(8), .OFS_W(16)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .mod_en_i(mod_en_i), .range_i(range_i),
    .dev_i(dev_i), .offset_o(offset_o), .range_err_o(range_err_o), .mult2_o(mult2_o)
  );

  function automatic int lim_of(input int r);
    return (r == 2) ? 2 * H : H;
  endfunction

  function automatic int exp_ofs();
    int l;
    if (!(men == 1 && mrng != 3)) return 0;
    l = lim_of(mrng);
    return ((2 * mp - l) * int'(dev_i)) / l;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock: advance model by the requirement rules, then sample at negedge
  task automatic step();
    int ne, nr;
    ne = int'(mod_en_i);
    nr = int'(range_i);
    if (!(ne == 1 && nr != 3) || ne != men || nr != mrng) begin
      mp = lim_of(nr) / 2;
      mdir = 1;
    end else if (mdir == 1) begin
      mp++;
      if (mp == lim_of(nr)) mdir = 0;
    end else begin
      mp--;
      if (mp == 0) mdir = 1;
    end
    men = ne;
    mrng = nr;
    @(negedge clk);
  endtask

  task automatic run_cmp(input int n, input string tag);
    acc = 0; vmax = -99999; vmin = 99999;
    for (int i = 0; i < n; i++) begin
      step();
      chk(int'(offset_o) == exp_ofs(), tag, int'(offset_o), exp_ofs());
      acc += int'(offset_o);
      if (int'(offset_o) > vmax) vmax = int'(offset_o);
      if (int'(offset_o) < vmin) vmin = int'(offset_o);
    end
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    mp = H / 2; mdir = 1; men = 1; mrng = 0;
    repeat (3) @(negedge clk);
    chk(offset_o == 0, "R1 offset", int'(offset_o), 0);
    chk(range_err_o == 0, "R1 err", int'(range_err_o), 0);
    chk(mult2_o == 0, "R1 mult2", int'(mult2_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    mp = H / 2 + 1;
    chk(int'(offset_o) == exp_ofs(), "R1 first step", int'(offset_o), exp_ofs());
  endtask

  task automatic t_short();
    range_i = 2'b00; dev_i = 8'd100; mod_en_i = 1'b1;
    run_cmp(2 * H, "R2 short ramp");
    chk(vmax == 100, "R2 peak max", vmax, 100);
    chk(vmin == -100, "R2 peak min", vmin, -100);
    chk(acc == 0, "R9 short sum", acc, 0);
    run_cmp(2 * H + 5, "R6 short formula");
  endtask

  task automatic t_range2x();
    range_i = 2'b01;
    step();
    chk(offset_o == 0, "R8 restart zero", int'(offset_o), 0);
    chk(mult2_o == 1, "R5 mult2 on", int'(mult2_o), 1);
    run_cmp(2 * H, "R8 after change");
    chk(acc == 0, "R9 2x sum", acc, 0);
    range_i = 2'b00;
    step();
    chk(mult2_o == 0, "R5 mult2 off", int'(mult2_o), 0);
  endtask

  task automatic t_long();
    range_i = 2'b10;
    step();
    chk(offset_o == 0, "R3 restart zero", int'(offset_o), 0);
    chk(mult2_o == 0, "R5 mult2 long", int'(mult2_o), 0);
    run_cmp(4 * H, "R3 long ramp");
    chk(vmax == 100, "R3 peak max", vmax, 100);
    chk(vmin == -100, "R3 peak min", vmin, -100);
    chk(acc == 0, "R9 long sum", acc, 0);
    run_cmp(H, "R3 long tail");
    chk(vmax == 100, "R3 turn after 2H", vmax, 100);
  endtask

  task automatic t_bad();
    range_i = 2'b11;
    for (int i = 0; i < 8; i++) begin
      step();
      chk(range_err_o == 1, "R4 err flag", int'(range_err_o), 1);
      chk(offset_o == 0, "R4 offset zero", int'(offset_o), 0);
    end
    range_i = 2'b00;
    step();
    chk(range_err_o == 0, "R4 err clear", int'(range_err_o), 0);
    chk(offset_o == 0, "R8 from bad zero", int'(offset_o), 0);
    run_cmp(H, "R4 resume");
  endtask

  task automatic t_enable();
    mod_en_i = 1'b0;
    for (int i = 0; i < 10; i++) begin
      step();
      chk(offset_o == 0, "R7 disabled", int'(offset_o), 0);
    end
    mod_en_i = 1'b1;
    step();
    chk(offset_o == 0, "R7 re-enable zero", int'(offset_o), 0);
    step();
    chk(int'(offset_o) == 33, "R7 rises after enable", int'(offset_o), 33);
    run_cmp(2 * H, "R7 running");
  endtask

  task automatic t_dev();
    dev_i = 8'd0;
    run_cmp(2 * H, "R6 dev zero");
    chk(vmax == 0 && vmin == 0, "R6 dev zero flat", vmax, 0);
    dev_i = 8'd255;
    run_cmp(2 * H, "R6 dev max");
    chk(vmax == 255, "R6 dev max peak", vmax, 255);
    chk(vmin == -255, "R6 dev max trough", vmin, -255);
    chk(acc == 0, "R9 dev max sum", acc, 0);
    dev_i = 8'd7;
    range_i = 2'b10;
    run_cmp(4 * H, "R6 truncation");
    chk(acc == 0, "R9 trunc sum", acc, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_short();
    t_range2x();
    t_long();
    t_bad();
    t_enable();
    t_dev();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule